// File: doc/BRIEF.md
# Clock-Stop Sleep and Wake Controller

This controller manages a digital domain whose only clock comes from an oscillator that can be switched off. The domain stops its own clock to save power. A small state machine runs on the domain clock. When software or a neighbouring block issues a sleep command, the machine raises a request that tells the oscillator to halt. It then parks in a dormant state and expects the clock to vanish.

Waking cannot depend on the missing clock. A capture cell clocked by the interrupt pin itself records the wake event. That cell raises a start request to the oscillator at once and withdraws the halt request. When the clock comes back, the oscillator reports that it is stable. A two-stage release chain then passes the event into the clock domain. Its first stage has its data input tied high. The chain is held cleared by the capture cell and advances only on edges where the oscillator reports stable. The state machine therefore sees a clean, synchronous wake. It then leaves the dormant state, clears the capture cell and returns to normal running.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edges after it is released, `state_o` reads 0 (running), and both `osc_stop_o` and `osc_start_o` are low. Reset assertion takes effect with no clock edge.
- R2: A high `sleep_req_i` sampled in the running state moves `state_o` to 1 (halt request) on that edge. The next edge moves it to 2 (dormant) with no further condition.
- R3: `osc_stop_o` is high from the edge that enters state 1 until the wake interrupt is captured, for any number of clocked cycles spent in state 2. It falls as soon as the interrupt is captured, with no clock edge.
- R4: A rising edge on `irq_i` while in state 1 or 2 drives `osc_start_o` high with no clock edge. The request stays high after the pin returns low, while the clock is absent.
- R5: The wake release advances only on clock edges where `osc_stable_i` is high. While it is low, the block stays in state 2 with `osc_start_o` high for any number of edges.
- R6: If the first stable edge after capture is edge a, then after edges a and a+1 the state is still 2. After edge a+2 the state is 3 (resuming) and `osc_start_o` is low.
- R7: After edge a+3 the state is 0 again, and `osc_stop_o` and `osc_start_o` are both low.
- R8: A rising edge on `irq_i` in state 0 is ignored. `osc_start_o` stays low and the state stays 0. The state machine never shows state 0 with `osc_start_o` high.
- R9: An interrupt captured in state 1, while the clock still runs and is stable, is not lost. With edge a being the edge that enters state 2, the wake follows the R6/R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock from the stoppable oscillator |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep command, sampled in the running state |
| irq_i | input | 1 | External wake interrupt, rising-edge captured without a clock |
| osc_stable_i | input | 1 | Oscillator reports a stable clock |
| osc_stop_o | output | 1 | Request to the oscillator to halt |
| osc_start_o | output | 1 | Request to the oscillator to run |
| state_o | output | 2 | Controller state: 0 run, 1 halt request, 2 dormant, 3 resuming |

## Verification
The two oscillator requests react to the interrupt with no clock edge. The bench therefore checks them while the clock is held still, a nanosecond after the pin pulse. The clocked results are counted in edges from the first edge with `osc_stable_i` high. The release completes one edge after that edge, the state machine enters state 3 two edges after it, and it is back in state 0 three edges after it. The bench samples half a period after each edge and sweeps the number of unstable restart edges and the number of clocked cycles spent dormant before the clock stops. It checks every one of those edges against the count.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_DORM  = 2'd2,
    ST_WAKE  = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_rst_sync.sv
`timescale 1ns/1ps
module swc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/swc_irq_capture.sv
`timescale 1ns/1ps
module swc_irq_capture (
  input  logic irq_i,
  input  logic arm_i,
  output logic pend_o
);
  logic clr;
  logic pend_q;

  // arm_i is a register output, so the clear is glitch free
  assign clr = ~arm_i;

  always_ff @(posedge irq_i or posedge clr) begin
    if (clr) pend_q <= 1'b0;
    else     pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/swc_release_sync.sv
`timescale 1ns/1ps
module swc_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic stable_i,
  output logic rel_o
);
  logic              chain_rst_n;
  logic [STAGES-1:0] shift_q;

  assign chain_rst_n = pend_i & rst_ni;

  always_ff @(posedge clk_i or negedge chain_rst_n) begin
    if (!chain_rst_n)  shift_q <= '0;
    else if (stable_i) shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = shift_q[STAGES-1];

  // R5: the release can only appear on an edge that saw a stable clock
  assert_rel_needs_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_o) |-> $past(stable_i));
endmodule

// File: rtl/swc_fsm.sv
`timescale 1ns/1ps
module swc_fsm
  import swc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       rel_i,
  output swc_state_e state_o,
  output logic       arm_o
);
  swc_state_e st_q, st_d;
  logic       arm_q, arm_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (sleep_i) st_d = ST_HALT;
      ST_HALT: st_d = ST_DORM;
      ST_DORM: if (rel_i)   st_d = ST_WAKE;
      ST_WAKE: if (!rel_i)  st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
    arm_d = (st_d == ST_HALT) || (st_d == ST_DORM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      arm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      arm_q <= arm_d;
    end
  end

  assign state_o = st_q;
  assign arm_o   = arm_q;

  assert_halt_to_dorm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT) |=> (st_q == ST_DORM));
  assert_dorm_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DORM && !rel_i) |=> (st_q == ST_DORM));
  assert_wake_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE) |=> (st_q == ST_WAKE || st_q == ST_RUN));
  assert_run_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !sleep_i) |=> (st_q == ST_RUN));
endmodule

// File: rtl/sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int REL_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       irq_i,
  input  logic       osc_stable_i,
  output logic       osc_stop_o,
  output logic       osc_start_o,
  output logic [1:0] state_o
);
  logic       rst_n;
  logic       arm;
  logic       pend;
  logic       rel;
  swc_state_e state;

  swc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  swc_irq_capture u_cap (
    .irq_i (irq_i),
    .arm_i (arm),
    .pend_o(pend)
  );

  swc_release_sync #(.STAGES(REL_STAGES)) u_rel (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .pend_i  (pend),
    .stable_i(osc_stable_i),
    .rel_o   (rel)
  );

  swc_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sleep_i(sleep_req_i),
    .rel_i  (rel),
    .state_o(state),
    .arm_o  (arm)
  );

  assign osc_stop_o  = arm & ~pend;
  assign osc_start_o = pend;
  assign state_o     = state;

  // R8: a captured wake never survives into the running state
  assert_run_no_start_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_RUN) |-> !osc_start_o);
  // R3: the halt request is present whenever the machine sits in the halt state
  assert_halt_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_HALT && !pend) |-> osc_stop_o);
endmodule

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       irq = 1'b0;
  logic       stable = 1'b1;
  logic       stop_o;
  logic       start_o;
  logic [1:0] st_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  sleep_wake_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .irq_i(irq),
    .osc_stable_i(stable), .osc_stop_o(stop_o), .osc_start_o(start_o),
    .state_o(st_o)
  );

  // one 125 MHz period; outputs are sampled 4 ns after the rising edge
  task automatic tick();
    #4 clk = 1'b1;
    #4 clk = 1'b0;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_irq();
    #1 irq = 1'b1;
    #1 irq = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(st_o, 0, "R1 state in reset");
    chk(stop_o, 0, "R1 stop in reset");
    chk(start_o, 0, "R1 start in reset");
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk(st_o, 0, "R1 state after reset");
    chk(stop_o | start_o, 0, "R1 requests after reset");
  endtask

  // checks from edge a (first stable edge) through the return to running
  task automatic wake_tail();
    stable = 1'b1;
    tick();
    chk(st_o, 2, "R6 state after edge a");
    tick();
    chk(st_o, 2, "R6 state after edge a+1");
    tick();
    chk(st_o, 3, "R6 state after edge a+2");
    chk(start_o, 0, "R6 start after edge a+2");
    tick();
    chk(st_o, 0, "R7 state after edge a+3");
    chk(stop_o | start_o, 0, "R7 requests after edge a+3");
  endtask

  initial begin
    do_reset();

    // R8: interrupt while running is ignored
    pulse_irq();
    chk(start_o, 0, "R8 start after irq in run");
    tick();
    chk(st_o, 0, "R8 state after irq in run");
    chk(start_o, 0, "R8 start one edge later");

    // sweep: k clocked dormant cycles, d unstable restart edges
    for (int k = 0; k < 3; k++) begin
      for (int d = 0; d < 6; d++) begin
        stable = 1'b1;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk(st_o, 1, "R2 state after sleep edge");
        chk(stop_o, 1, "R3 stop in halt");
        tick();
        chk(st_o, 2, "R2 state one edge later");
        for (int j = 0; j < k; j++) begin
          tick();
          chk(stop_o, 1, "R3 stop while dormant");
          chk(st_o, 2, "R3 state while dormant");
        end
        stable = 1'b0;
        #20;
        pulse_irq();
        chk(start_o, 1, "R4 start without clock");
        chk(stop_o, 0, "R3 stop drops without clock");
        #20;
        chk(start_o, 1, "R4 start held after pulse");
        for (int j = 0; j < d; j++) begin
          tick();
          chk(st_o, 2, "R5 state while unstable");
          chk(start_o, 1, "R5 start while unstable");
        end
        wake_tail();
      end
    end

    // R9: interrupt in the halt state while the clock still runs
    stable = 1'b1;
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk(st_o, 1, "R9 in halt");
    pulse_irq();
    chk(start_o, 1, "R9 start in halt");
    chk(stop_o, 0, "R9 stop in halt");
    tick();
    chk(st_o, 2, "R9 after edge a");
    tick();
    chk(st_o, 2, "R9 after edge a+1");
    tick();
    chk(st_o, 3, "R9 after edge a+2");
    tick();
    chk(st_o, 0, "R9 after edge a+3");

    // R1: reset while dormant with a captured interrupt
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    tick();
    stable = 1'b0;
    pulse_irq();
    chk(start_o, 1, "R4 start before reset");
    do_reset();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule